// File: doc/BRIEF.md
# Two-Bank Interleaved Word Memory

This block offers one word-addressed memory port backed by two equal behavioural RAM banks. The lowest address bit chooses the bank and the remaining upper bits choose the word inside it. On any access only the chosen bank is enabled, so the other bank's array and output register stay quiet during that cycle. Consecutive addresses fall in alternate banks.

A caller drives an address, a write strobe with write data, and a read strobe. Writes land on the rising clock edge. Read data appears on the cycle after the read strobe. A flip-flop holds the bank bit of the last read, and that stored bit steers the output multiplexer. The read port therefore keeps showing the last read word until the next read. The address width defaults to 12 bits, giving two banks of 2K words each. Setting it to 15 bits gives the full 32K-word arrangement with two 16K-word banks.

Top module: `dual_bank_mem`

## Requirements
- R1: While reset is asserted, and after it is released, `rdata` reads zero until the first read completes. Reset does not clear stored words.
- R2: `bank_act` is 2'b01 when `addr[0]`=0 and 2'b10 when `addr[0]`=1, during any cycle with `wr_en` or `rd_en` high. It is 2'b00 in every other cycle, so at most one bank is ever enabled.
- R3: A write stores `wdata` at word `addr[ADDR_W-1:1]` of bank `addr[0]`. The word at the same index in the other bank is left unchanged.
- R4: When `rd_en` is high in one cycle, `rdata` shows the stored word in the next cycle.
- R5: The registered bank bit steers the output. Back-to-back reads that alternate between banks each return their own bank's word.
- R6: In a cycle with `rd_en` low, `rdata` keeps its previous value.
- R7: When `rd_en` and `wr_en` are both high for the same address, `rdata` returns the word held before the write. The new word is returned by a later read.
- R8: An even address and the odd address above it (the same index in both banks) are separate storage locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address; bit 0 selects the bank |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| bank_act | output | 2 | Per-bank enable for the current cycle |

## Verification
The assertions assume that `addr`, `wr_en` and `rd_en` are settled before each rising edge, with no X values during reset-free operation. They also assume that a read of a word never written may return X, so they make no claim about data values. The stimulus changes inputs only on the falling clock edge. It reads only addresses written earlier in the run, which keeps every data comparison defined. Checks of bank enables and output hold rely only on port activity, so they stay valid for every address pattern the stimulus uses.

// File: rtl/dual_bank_pkg.sv
package dual_bank_pkg;
   localparam int unsigned NUM_BANKS = 2;

   typedef enum logic [0:0] {
      BANK_EVEN = 1'b0,
      BANK_ODD  = 1'b1
   } bank_sel_e;

   function automatic logic [NUM_BANKS-1:0] bank_onehot(input logic sel, input logic any_access);
      logic [NUM_BANKS-1:0] r;
      r = '0;
      if (any_access) r[sel] = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/dual_bank_decode.sv
module dual_bank_decode #(
   parameter int unsigned ADDR_W = 12,
   localparam int unsigned IDX_W = ADDR_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [1:0]        bank_en,
   output logic [1:0]        bank_we,
   output logic [1:0]        bank_re,
   output logic [IDX_W-1:0]  word_idx,
   output logic              bank_bit
);
   import dual_bank_pkg::*;

   logic access;

   assign access   = wr_en | rd_en;
   assign word_idx = addr[ADDR_W-1:1];
   assign bank_bit = addr[0];

   for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
      logic hit;
      assign hit        = (bank_bit == b[0]);
      assign bank_en[b] = access & hit;
      assign bank_we[b] = wr_en & hit;
      assign bank_re[b] = rd_en & hit;
   end
endmodule

// File: rtl/dual_bank_sram.sv
module dual_bank_sram #(
   parameter int unsigned IDX_W      = 11,
   parameter int unsigned DATA_W     = 32,
   parameter bit          RESET_DOUT = 1'b1,
   localparam int unsigned DEPTH     = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic              re,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) cells[idx] <= din;
   end

   if (RESET_DOUT) begin : g_rst_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        dout <= '0;
         else if (en && re) dout <= cells[idx];
      end
   end else begin : g_free_out
      always_ff @(posedge clk) begin
         if (en && re) dout <= cells[idx];
      end
   end
endmodule

// File: rtl/dual_bank_steer.sv
module dual_bank_steer #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              bank_bit,
   input  logic [DATA_W-1:0] dout0,
   input  logic [DATA_W-1:0] dout1,
   output logic [DATA_W-1:0] rdata
);
   import dual_bank_pkg::*;

   bank_sel_e sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sel_q <= BANK_EVEN;
      else if (rd_en) sel_q <= bank_sel_e'(bank_bit);
   end

   always_comb begin
      unique case (sel_q)
         BANK_EVEN: rdata = dout0;
         BANK_ODD:  rdata = dout1;
         default:   rdata = dout0;
      endcase
   end
endmodule

// File: rtl/dual_bank_mem.sv
module dual_bank_mem #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter bit          RESET_DOUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        bank_act
);
   import dual_bank_pkg::*;

   localparam int unsigned IDX_W = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("dual_bank_mem: ADDR_W must be at least 2");
   end
   if (ADDR_W > 16) begin : g_bad_depth
      $error("dual_bank_mem: ADDR_W above 16 gives banks too deep for behavioural arrays");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dual_bank_mem: DATA_W must be at least 1");
   end
   if (NUM_BANKS != 2) begin : g_bad_banks
      $error("dual_bank_mem: exactly two banks are supported");
   end

   logic [1:0]        bank_en;
   logic [1:0]        bank_we;
   logic [1:0]        bank_re;
   logic [IDX_W-1:0]  word_idx;
   logic              bank_bit;
   logic [DATA_W-1:0] dout [2];

   dual_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr     (addr),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .bank_en  (bank_en),
      .bank_we  (bank_we),
      .bank_re  (bank_re),
      .word_idx (word_idx),
      .bank_bit (bank_bit)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      dual_bank_sram #(
         .IDX_W      (IDX_W),
         .DATA_W     (DATA_W),
         .RESET_DOUT (RESET_DOUT)
      ) u_sram (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (bank_en[b]),
         .we   (bank_we[b]),
         .re   (bank_re[b]),
         .idx  (word_idx),
         .din  (wdata),
         .dout (dout[b])
      );
   end

   dual_bank_steer #(.DATA_W(DATA_W)) u_steer (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .bank_bit(bank_bit),
      .dout0   (dout[0]),
      .dout1   (dout[1]),
      .rdata   (rdata)
   );

   assign bank_act = bank_en;
endmodule

// File: rtl/dual_bank_mem_chk.sv
module dual_bank_mem_chk #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        bank_act
);
   logic [15:0] acc_cnt;
   logic [15:0] act_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cnt <= '0;
         act_cnt <= '0;
      end else begin
         acc_cnt <= acc_cnt + {15'd0, (wr_en | rd_en)};
         act_cnt <= act_cnt + 16'($countones(bank_act));
      end
   end

   // R2
   one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_act));

   // R2
   bank_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || rd_en) |-> bank_act[addr[0]]);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en || rd_en) |-> (bank_act == 2'b00));

   // R2
   act_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_cnt == act_cnt);

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

bind dual_bank_mem dual_bank_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .rdata   (rdata),
   .bank_act(bank_act)
);

// File: tb/dual_bank_mem_bench.sv
module dual_bank_mem_bench;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int NV = 20;
   // vector: {req[3:0], op[1:0], addr[11:0], data[31:0]}; op 0 idle, 1 write, 2 read, 3 read+write
   localparam logic [49:0] VEC [NV] = '{
      {4'd3, 2'd1, 12'h000, 32'hA0A0A0A0},
      {4'd3, 2'd1, 12'h001, 32'hB1B1B1B1},
      {4'd8, 2'd2, 12'h000, 32'h0},
      {4'd8, 2'd2, 12'h001, 32'h0},
      {4'd3, 2'd1, 12'h0FE, 32'h12345678},
      {4'd3, 2'd1, 12'h0FF, 32'h9ABCDEF0},
      {4'd5, 2'd2, 12'h0FE, 32'h0},
      {4'd5, 2'd2, 12'h001, 32'h0},
      {4'd5, 2'd2, 12'h0FF, 32'h0},
      {4'd6, 2'd0, 12'h0FF, 32'h0},
      {4'd6, 2'd0, 12'h123, 32'h0},
      {4'd7, 2'd3, 12'h0FE, 32'h0BADF00D},
      {4'd4, 2'd2, 12'h0FE, 32'h0},
      {4'd3, 2'd1, 12'hFFF, 32'hCAFEF00D},
      {4'd3, 2'd1, 12'hFFE, 32'h55AA55AA},
      {4'd4, 2'd2, 12'hFFF, 32'h0},
      {4'd3, 2'd1, 12'h000, 32'hDEADBEEF},
      {4'd3, 2'd2, 12'h001, 32'h0},
      {4'd3, 2'd2, 12'h000, 32'h0},
      {4'd6, 2'd0, 12'h000, 32'h0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rdata;
   logic [1:0]    bank_act;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [DW-1:0] ref_mem [1 << AW];
   logic [DW-1:0] shown;
   logic [DW-1:0] pend_val;
   bit            pend;
   string         pend_tag;

   always #5 clk = ~clk;

   dual_bank_mem #(.ADDR_W(AW), .DATA_W(DW)) u_dual_bank_mem (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .bank_act(bank_act)
   );

   function automatic string tag_of(input logic [3:0] r);
      case (r)
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input logic [3:0] req, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [1:0] exp_act;
      @(negedge clk);
      if (pend) begin
         chk(pend_tag, rdata, pend_val);
         shown = pend_val;
      end else begin
         chk("R6", rdata, shown);
      end
      pend  = 1'b0;
      addr  = a;
      wdata = d;
      wr_en = op[0];
      rd_en = op[1];
      #1;
      exp_act = (op != 2'd0) ? (a[0] ? 2'b10 : 2'b01) : 2'b00;
      chk("R2", {30'd0, bank_act}, {30'd0, exp_act});
      if (op[1]) begin
         pend     = 1'b1;
         pend_val = ref_mem[a];
         pend_tag = tag_of(req);
      end
      if (op[0]) ref_mem[a] = d;
   endtask

   initial begin
      shown = '0;
      pend  = 1'b0;
      pend_val = '0;
      pend_tag = "R4";
      #1;
      chk("R1", rdata, '0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", rdata, '0);
      chk("R2", {30'd0, bank_act}, 32'd0);
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][49:46], VEC[i][45:44], VEC[i][43:32], VEC[i][31:0]);
      end
      step(4'd6, 2'd0, '0, '0);
      step(4'd6, 2'd0, '0, '0);
      // R1: reset mid-run clears the read port but keeps stored words
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      shown = '0;
      pend  = 1'b0;
      step(4'd6, 2'd0, '0, '0);
      step(4'd4, 2'd2, 12'h0FF, '0);
      step(4'd8, 2'd2, 12'hFFE, '0);
      step(4'd6, 2'd0, '0, '0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule